// File: doc/BRIEF.md
# Pointer-Pair General-Purpose Register File

This block is the working register store of a small 8-bit processing core. It holds thirty-two byte-wide registers. Two read ports answer in the same cycle their index arrives, so the core can fetch both operands of a register-to-register operation without waiting. One write port updates a register on the rising clock edge. A read of a register in the same cycle it is written returns the value it held before that edge.

Instructions that combine a register with a constant carry only a 4-bit register field. The file maps such a field `d` onto register `16 + d`, so those instructions reach only the upper half. Both the write port and read port A accept this narrow form, selected by a per-port flag. Read port B and the full-width form of the other ports reach every register.

The two highest registers form a 16-bit pointer: register 30 is the low byte and register 31 is the high byte. The pointer is driven out of the block for indirect addressing. A third read port uses that pointer to address the file itself. For this port only the low byte counts, and only its low five bits pick the register.

Top module: `gprf_ptr_file`

## Requirements
- R1: When `rst` is high at a rising edge, every register becomes 0x00. After reset, every read port and `ptr_o` show zero.
- R2: With `wr_en` high and `wr_imm` low, the register named by the full 5-bit `wr_addr` (0 to 31) takes `wr_data` at the rising edge. Both read ports show the new value from the next cycle on.
- R3: When a register is written and read in the same cycle, the read returns the value from before the edge. The new value appears on the read port in the following cycle.
- R4: With `wr_en` and `wr_imm` high, the write goes to register 16 + `wr_addr[3:0]`. `wr_addr[4]` is ignored, and registers 0 to 15 do not change.
- R5: With `rd_a_imm` high, `rd_a_data` returns register 16 + `rd_a_addr[3:0]`, whatever the value of `rd_a_addr[4]`. With `rd_a_imm` low, port A decodes all five bits.
- R6: `ptr_o[7:0]` always equals register 30 and `ptr_o[15:8]` always equals register 31.
- R7: `ind_data` returns the register indexed by bits [4:0] of register 30. Register 31 and bits [7:5] of register 30 have no effect on which register is selected.
- R8: Ports A and B return two different registers in the same cycle, with no interference between them.
- R9: With `wr_en` low, no register changes, whatever is on `wr_addr`, `wr_data` and `wr_imm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_imm | input | 1 | Write index is a 4-bit upper-half field |
| wr_addr | input | 5 | Write index |
| wr_data | input | 8 | Write data |
| rd_a_imm | input | 1 | Port A index is a 4-bit upper-half field |
| rd_a_addr | input | 5 | Port A index |
| rd_a_data | output | 8 | Port A data, combinational |
| rd_b_addr | input | 5 | Port B index, full range |
| rd_b_data | output | 8 | Port B data, combinational |
| ind_data | output | 8 | Data at the register indexed by the pointer low byte |
| ptr_o | output | 16 | Pointer formed by registers 31:30 |

## Verification
Read results on ports A, B and the indirect port are due in the cycle their index is applied. The bench changes inputs on the falling edge and samples one nanosecond later, before any rising edge. A write takes effect at the next rising edge, and so does every pointer and indirect-port change that follows from it. These results are sampled at the falling edge after that rising edge. The same-cycle case samples both before and after the edge, which shows the old value first and the new value second.

// File: rtl/gprf_pkg.sv
package gprf_pkg;
  localparam int unsigned GPRF_REGS   = 32;
  localparam int unsigned GPRF_DATA_W = 8;
  localparam int unsigned GPRF_ADDR_W = $clog2(GPRF_REGS);
endpackage

// File: rtl/gprf_index_map.sv
// Turns a port index into a physical register number. A narrow
// (immediate-class) field selects the upper half of the file.
module gprf_index_map #(
  parameter int unsigned AW = gprf_pkg::GPRF_ADDR_W
) (
  input  logic          narrow,
  input  logic [AW-1:0] field,
  output logic [AW-1:0] phys
);
  localparam int unsigned NW = AW - 1;

  always_comb begin
    if (narrow) phys = {1'b1, field[NW-1:0]};
    else        phys = field;
  end
endmodule

// File: rtl/gprf_store.sv
// Flop-based storage: synchronous write, synchronous clear.
module gprf_store #(
  parameter int unsigned N  = gprf_pkg::GPRF_REGS,
  parameter int unsigned DW = gprf_pkg::GPRF_DATA_W,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [DW-1:0]         wdata,
  output logic [N-1:0][DW-1:0]  regs_q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                           regs_q[i] <= '0;
      else if (we && waddr == AW'(i))    regs_q[i] <= wdata;
    end
  end

  // R9: nothing moves without a write
  a_r9_no_write_no_change: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(regs_q));

  // R2: the addressed register holds the written byte after the edge
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> regs_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/gprf_read_port.sv
// Combinational read mux over the register array.
module gprf_read_port #(
  parameter int unsigned N  = gprf_pkg::GPRF_REGS,
  parameter int unsigned DW = gprf_pkg::GPRF_DATA_W,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic [N-1:0][DW-1:0] regs,
  input  logic [AW-1:0]        addr,
  output logic [DW-1:0]        data
);
  assign data = regs[addr];
endmodule

// File: rtl/gprf_ptr_file.sv
module gprf_ptr_file #(
  parameter int unsigned N  = gprf_pkg::GPRF_REGS,
  parameter int unsigned DW = gprf_pkg::GPRF_DATA_W,
  localparam int unsigned AW    = $clog2(N),
  localparam int unsigned PTR_W = 2 * DW,
  localparam int unsigned HALF  = N / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_imm,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_a_imm,
  input  logic [AW-1:0]    rd_a_addr,
  output logic [DW-1:0]    rd_a_data,
  input  logic [AW-1:0]    rd_b_addr,
  output logic [DW-1:0]    rd_b_data,
  output logic [DW-1:0]    ind_data,
  output logic [PTR_W-1:0] ptr_o
);
  logic [N-1:0][DW-1:0] regs_q;
  logic [AW-1:0]        wr_phys;
  logic [AW-1:0]        rd_a_phys;
  logic [AW-1:0]        ind_idx;

  gprf_index_map #(.AW(AW)) u_wmap (
    .narrow(wr_imm), .field(wr_addr), .phys(wr_phys));

  gprf_index_map #(.AW(AW)) u_amap (
    .narrow(rd_a_imm), .field(rd_a_addr), .phys(rd_a_phys));

  gprf_store #(.N(N), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_phys),
    .wdata(wr_data), .regs_q(regs_q));

  // pointer pair: top two registers, low byte first
  assign ptr_o   = {regs_q[N-1], regs_q[N-2]};
  // indirect index: only the low bits of the pointer's low byte
  assign ind_idx = regs_q[N-2][AW-1:0];

  gprf_read_port #(.N(N), .DW(DW)) u_rda (
    .regs(regs_q), .addr(rd_a_phys), .data(rd_a_data));
  gprf_read_port #(.N(N), .DW(DW)) u_rdb (
    .regs(regs_q), .addr(rd_b_addr), .data(rd_b_data));
  gprf_read_port #(.N(N), .DW(DW)) u_rdi (
    .regs(regs_q), .addr(ind_idx), .data(ind_data));

  // R4: narrow writes never touch the lower half
  a_r4_imm_spares_lower: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_imm) |=> $stable(regs_q[HALF-1:0]));

  // R6: a write to the pointer low register shows on the pointer next cycle
  a_r6_ptr_low_follows_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_phys == AW'(N-2)) |=> ptr_o[DW-1:0] == $past(wr_data));

  // R7: indirect port agrees with port B when both point at the same register
  a_r7_ind_matches_b: assert property (@(posedge clk) disable iff (rst)
    (rd_b_addr == ptr_o[AW-1:0]) |-> rd_b_data == ind_data);
endmodule

// File: tb/gprf_ptr_file_tb.sv
module gprf_ptr_file_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, wr_imm, rd_a_imm;
  logic [4:0]  wr_addr, rd_a_addr, rd_b_addr;
  logic [7:0]  wr_data, rd_a_data, rd_b_data, ind_data;
  logic [15:0] ptr_o;
  logic [7:0]  model [32];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  gprf_ptr_file u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_imm(wr_imm), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_a_imm(rd_a_imm), .rd_a_addr(rd_a_addr),
    .rd_a_data(rd_a_data), .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .ind_data(ind_data), .ptr_o(ptr_o));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // write through the port; the model follows the requirement mapping
  task automatic do_write(input logic imm, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_imm = imm; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    model[imm ? {1'b1, a[3:0]} : a] = d;
  endtask

  task automatic t_reset();
    rst = 1'b1; wr_en = 1'b0; wr_imm = 1'b0; wr_addr = '0; wr_data = '0;
    rd_a_imm = 1'b0; rd_a_addr = '0; rd_b_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    for (int i = 0; i < 32; i++) begin
      rd_a_addr = 5'(i); rd_b_addr = 5'(31 - i); #1;
      chk("R1 port A after reset", {8'h0, rd_a_data}, 16'h0);
      chk("R1 port B after reset", {8'h0, rd_b_data}, 16'h0);
    end
    chk("R1 pointer after reset", ptr_o, 16'h0);
  endtask

  task automatic t_full_writes();
    for (int i = 0; i < 32; i++) do_write(1'b0, 5'(i), 8'(i * 7 + 3));
    for (int i = 0; i < 32; i++) begin
      rd_a_imm = 1'b0; rd_a_addr = 5'(i); rd_b_addr = 5'(i); #1;
      chk("R2 port A full write", {8'h0, rd_a_data}, {8'h0, model[i]});
      chk("R2 port B full write", {8'h0, rd_b_data}, {8'h0, model[i]});
    end
  endtask

  task automatic t_two_ports();
    rd_a_imm = 1'b0; rd_a_addr = 5'd2; rd_b_addr = 5'd29; #1;
    chk("R8 port A independent", {8'h0, rd_a_data}, {8'h0, model[2]});
    chk("R8 port B independent", {8'h0, rd_b_data}, {8'h0, model[29]});
    rd_a_addr = 5'd17; rd_b_addr = 5'd0; #1;
    chk("R8 port A swap", {8'h0, rd_a_data}, {8'h0, model[17]});
    chk("R8 port B swap", {8'h0, rd_b_data}, {8'h0, model[0]});
  endtask

  task automatic t_same_cycle();
    logic [7:0] old = model[5];
    @(negedge clk);
    rd_a_imm = 1'b0; rd_a_addr = 5'd5; rd_b_addr = 5'd5;
    wr_en = 1'b1; wr_imm = 1'b0; wr_addr = 5'd5; wr_data = 8'hA5; #1;
    chk("R3 old value before edge", {8'h0, rd_a_data}, {8'h0, old});
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0; model[5] = 8'hA5; #1;
    chk("R3 new value after edge A", {8'h0, rd_a_data}, 16'h00A5);
    chk("R3 new value after edge B", {8'h0, rd_b_data}, 16'h00A5);
  endtask

  task automatic t_imm_write();
    do_write(1'b1, 5'b0_0011, 8'h3C);   // reg 19
    do_write(1'b1, 5'b1_0100, 8'h4D);   // bit 4 ignored: reg 20
    rd_a_imm = 1'b0; rd_b_addr = 5'd19; rd_a_addr = 5'd20; #1;
    chk("R4 narrow write to 19", {8'h0, rd_b_data}, 16'h003C);
    chk("R4 narrow write to 20", {8'h0, rd_a_data}, 16'h004D);
    for (int i = 0; i < 16; i++) begin
      rd_b_addr = 5'(i); #1;
      chk("R4 lower half untouched", {8'h0, rd_b_data}, {8'h0, model[i]});
    end
  endtask

  task automatic t_imm_read();
    rd_a_imm = 1'b1;
    for (int i = 0; i < 16; i++) begin
      rd_a_addr = {1'(i & 1), 4'(i)}; #1;
      chk("R5 narrow read", {8'h0, rd_a_data}, {8'h0, model[16 + i]});
    end
    rd_a_imm = 1'b0; rd_a_addr = 5'd3; #1;
    chk("R5 full read low half", {8'h0, rd_a_data}, {8'h0, model[3]});
  endtask

  task automatic t_pointer();
    do_write(1'b0, 5'd30, 8'h23);
    do_write(1'b1, 5'd15, 8'hFF);       // narrow 15 -> reg 31
    chk("R6 pointer pair", ptr_o, 16'hFF23);
    chk("R7 indirect low bits", {8'h0, ind_data}, {8'h0, model[3]});
    do_write(1'b0, 5'd30, 8'hE7);       // upper bits set, index 7
    chk("R6 pointer low byte", ptr_o, 16'hFFE7);
    chk("R7 upper bits of low byte ignored", {8'h0, ind_data}, {8'h0, model[7]});
    do_write(1'b0, 5'd31, 8'h00);
    chk("R7 high byte ignored", {8'h0, ind_data}, {8'h0, model[7]});
    chk("R6 pointer high byte", ptr_o, 16'h00E7);
    do_write(1'b0, 5'd30, 8'h1E);       // points at itself
    chk("R7 self index", {8'h0, ind_data}, 16'h001E);
  endtask

  task automatic t_hold();
    @(negedge clk);
    wr_en = 1'b0; wr_imm = 1'b0; wr_addr = 5'd9; wr_data = 8'h99;
    @(posedge clk);
    wr_imm = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_b_addr = 5'd9; rd_a_imm = 1'b0; rd_a_addr = 5'd25; #1;
    chk("R9 no write reg 9", {8'h0, rd_b_data}, {8'h0, model[9]});
    chk("R9 no write reg 25", {8'h0, rd_a_data}, {8'h0, model[25]});
  endtask

  initial begin
    t_reset();
    t_full_writes();
    t_two_ports();
    t_same_cycle();
    t_imm_write();
    t_imm_read();
    t_pointer();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule